// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the memory-mapped control and status side of an I2C master. Software writes bus commands into a small command queue and takes received bytes out of a receive queue. A separate byte engine, outside this block, consumes the commands and returns the received bytes. The block also holds the configuration that the engine needs: the core enable, the bus speed selection, and three timing counts for the SCL low phase, the SCL high phase and the SDA hold time.

Each queue has a programmable threshold. The threshold drives a level-type ready condition: command space is available, or receive data is waiting. Three error conditions latch until software clears them: the engine saw a NACK, the engine lost arbitration, or a received byte found the receive queue full. All five conditions sit in one status word, which has a matching enable word. The enabled conditions combine into a single registered interrupt line.

The register port is a simple 32-bit read/write strobe interface with byte offsets. Read data is registered and appears the cycle after the read strobe.

Top module: `i2cm_csr_front`

## Requirements
- R1: After a synchronous reset, the control word, the interrupt enable word, the timing counts, both queue levels, `cmd_valid` and `irq` are all 0. The status word at offset 0x10 then reads 0x01, because an empty command queue with threshold 0 reports ready.
- R2: While the core is enabled, a write to offset 0x00 appends `wdata[9:0]` to the command queue. The field layout is bit 9 start, bit 8 stop and bits 7:0 the byte. The oldest entry is shown on `cmd_data`, qualified by `cmd_valid`. `cmd_pop` removes that entry. Offset 0x18 reads the fill level. A write to a full queue, whose depth is 4 by default, is dropped.
- R3: A pulse on `rx_push` appends `rx_byte` to the receive queue. A read of offset 0x04 returns the oldest byte in bits 7:0 and removes it. Offset 0x1C reads the fill level. A read of an empty queue returns 0 and leaves the level at 0.
- R4: If `rx_push` arrives while the receive queue is full and no read pops it in the same cycle, the byte is discarded and status bit 4 (receive overflow) is set.
- R5: The control word at offset 0x08 is read/write. Its fields are bit 0 core enable, bit 1 fast bus speed, bits 3:2 command threshold and bits 5:4 receive threshold. Bits 0 and 1 drive `core_en` and `fast_mode`.
- R6: Status bit 0 (command ready) is 1 exactly when the command level is at or below the command threshold.
- R7: Status bit 1 (receive ready) is 1 exactly when the receive level is above the receive threshold. Threshold 0 therefore fires at one byte.
- R8: A pulse on `nack_evt` sets status bit 2, and a pulse on `arb_evt` sets status bit 3. Bits 2 to 4 hold until a write to offset 0x10 with a 1 in that bit position. Writing 0 has no effect. A set and a clear in the same cycle leave the bit set.
- R9: `irq` is registered. It is 1 in the cycle after any status bit is 1 while the same bit is 1 in the enable word at offset 0x0C. The enable word uses the same bit positions as the status word.
- R10: While the core enable is 0, both queues are emptied. Command writes and `rx_push` are ignored, and no overflow is recorded.
- R11: Offsets 0x20, 0x24 and 0x28 are read/write registers holding the SCL low count, the SCL high count and the SDA hold count. They drive `scl_lo_cnt`, `scl_hi_cnt` and `sda_hold_cnt`. Bit 0 of the read-only word at offset 0x14 reflects `core_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| cmd_valid | output | 1 | Command queue holds an entry |
| cmd_data | output | 10 | Oldest command: start, stop, byte |
| cmd_pop | input | 1 | Engine takes the oldest command |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| nack_evt | input | 1 | Engine saw a NACK (one-cycle pulse) |
| arb_evt | input | 1 | Engine lost arbitration (one-cycle pulse) |
| core_busy | input | 1 | Engine is not idle |
| core_en | output | 1 | Core enable to the engine |
| fast_mode | output | 1 | Fast bus speed selected |
| scl_lo_cnt | output | CNT_W | SCL low phase count |
| scl_hi_cnt | output | CNT_W | SCL high phase count |
| sda_hold_cnt | output | CNT_W | SDA hold count |
| irq | output | 1 | Combined interrupt request |

## Verification
The checks assume that the engine raises `nack_evt` and `arb_evt` as single-cycle pulses and pulses `cmd_pop` only while `cmd_valid` is high. They also assume that `reg_wr` and `reg_rd` are never asserted in the same cycle. The bench drives every strobe for exactly one cycle on the falling edge and pops commands only after it has seen `cmd_valid`, so it stays within these conditions. Overflow, the coincident set-and-clear case and the flush on disable are all produced on purpose, so the sticky-bit and flush properties are exercised at their boundaries rather than assumed.

// File: rtl/i2cm_csr_pkg.sv
package i2cm_csr_pkg;

  localparam int CMD_W  = 10;
  localparam int BYTE_W = 8;
  localparam int IRQ_N  = 5;

  // status / enable bit positions (software decodes these)
  localparam int IRQ_TXRDY = 0;
  localparam int IRQ_RXRDY = 1;
  localparam int IRQ_NACK  = 2;
  localparam int IRQ_ARB   = 3;
  localparam int IRQ_RXOF  = 4;
  localparam int STK_N     = IRQ_RXOF - IRQ_NACK + 1;

  // register byte offsets
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_RXD  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_IEN  = 8'h0C;
  localparam logic [7:0] OFS_ISR  = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_CLVL = 8'h18;
  localparam logic [7:0] OFS_RLVL = 8'h1C;
  localparam logic [7:0] OFS_SCLL = 8'h20;
  localparam logic [7:0] OFS_SCLH = 8'h24;
  localparam logic [7:0] OFS_HOLD = 8'h28;

  typedef struct packed {
    logic [1:0] rx_thr;
    logic [1:0] cmd_thr;
    logic       fast;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/i2cm_sfifo.sv
module i2cm_sfifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic          pop_ok, push_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == LW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= ptr_inc(wp_q);
      if (pop_ok)  rp_q <= ptr_inc(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem[rp_q];
  assign level = cnt_q;

endmodule

// File: rtl/i2cm_irq_unit.sv
module i2cm_irq_unit
  import i2cm_csr_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LW-1:0]    cmd_lvl,
  input  logic [LW-1:0]    rx_lvl,
  input  logic [1:0]       cmd_thr,
  input  logic [1:0]       rx_thr,
  input  logic             nack_evt,
  input  logic             arb_evt,
  input  logic             ovf_evt,
  input  logic             clr_wr,
  input  logic [STK_N-1:0] clr_bits,
  input  logic [IRQ_N-1:0] ien,
  output logic [IRQ_N-1:0] isr,
  output logic             irq
);

  logic             txrdy, rxrdy;
  logic [STK_N-1:0] stk_q, stk_set;
  logic             irq_q;

  assign txrdy   = int'(cmd_lvl) <= int'(cmd_thr);
  assign rxrdy   = int'(rx_lvl)  >  int'(rx_thr);
  assign stk_set = {ovf_evt, arb_evt, nack_evt};

  // sticky flags: a new event wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) begin
      stk_q <= '0;
    end else begin
      for (int i = 0; i < STK_N; i++)
        stk_q[i] <= stk_set[i] | (stk_q[i] & ~(clr_wr & clr_bits[i]));
    end
  end

  assign isr = {stk_q, rxrdy, txrdy};

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(isr & ien);
  end

  assign irq = irq_q;

endmodule

// File: rtl/i2cm_regbank.sv
module i2cm_regbank
  import i2cm_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16,
  parameter int LW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [BYTE_W-1:0] rx_head,
  input  logic              rx_empty,
  input  logic [LW-1:0]     cmd_lvl,
  input  logic [LW-1:0]     rx_lvl,
  input  logic [IRQ_N-1:0]  isr,
  input  logic              core_busy,
  output ctrl_t             ctrl,
  output logic [IRQ_N-1:0]  ien,
  output logic [CNT_W-1:0]  scl_lo,
  output logic [CNT_W-1:0]  scl_hi,
  output logic [CNT_W-1:0]  sda_hold,
  output logic              cmd_wr,
  output logic [CMD_W-1:0]  cmd_wdata,
  output logic              rx_rd,
  output logic              isr_wr,
  output logic [STK_N-1:0]  isr_clr,
  output logic [31:0]       rdata
);

  ctrl_t             ctrl_q;
  logic [IRQ_N-1:0]  ien_q;
  logic [CNT_W-1:0]  scl_lo_q, scl_hi_q, hold_q;
  logic [31:0]       rd_mux, rdata_q;
  logic              unused_wdata;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign unused_wdata = ^wdata;

  assign cmd_wr    = wr_en && hit(addr, OFS_CMD);
  assign cmd_wdata = wdata[CMD_W-1:0];
  assign rx_rd     = rd_en && hit(addr, OFS_RXD);
  assign isr_wr    = wr_en && hit(addr, OFS_ISR);
  assign isr_clr   = wdata[IRQ_RXOF:IRQ_NACK];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      scl_lo_q <= '0;
      scl_hi_q <= '0;
      hold_q   <= '0;
    end else if (wr_en) begin
      if (hit(addr, OFS_CTRL)) ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (hit(addr, OFS_IEN))  ien_q    <= wdata[IRQ_N-1:0];
      if (hit(addr, OFS_SCLL)) scl_lo_q <= wdata[CNT_W-1:0];
      if (hit(addr, OFS_SCLH)) scl_hi_q <= wdata[CNT_W-1:0];
      if (hit(addr, OFS_HOLD)) hold_q   <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit(addr, OFS_RXD))  rd_mux = rx_empty ? 32'd0 : 32'(rx_head);
    if (hit(addr, OFS_CTRL)) rd_mux = 32'(ctrl_q);
    if (hit(addr, OFS_IEN))  rd_mux = 32'(ien_q);
    if (hit(addr, OFS_ISR))  rd_mux = 32'(isr);
    if (hit(addr, OFS_STAT)) rd_mux = 32'(core_busy);
    if (hit(addr, OFS_CLVL)) rd_mux = 32'(cmd_lvl);
    if (hit(addr, OFS_RLVL)) rd_mux = 32'(rx_lvl);
    if (hit(addr, OFS_SCLL)) rd_mux = 32'(scl_lo_q);
    if (hit(addr, OFS_SCLH)) rd_mux = 32'(scl_hi_q);
    if (hit(addr, OFS_HOLD)) rd_mux = 32'(hold_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign ctrl     = ctrl_q;
  assign ien      = ien_q;
  assign scl_lo   = scl_lo_q;
  assign scl_hi   = scl_hi_q;
  assign sda_hold = hold_q;
  assign rdata    = rdata_q;

endmodule

// File: rtl/i2cm_csr_front.sv
module i2cm_csr_front
  import i2cm_csr_pkg::*;
#(
  parameter  int DEPTH  = 4,
  parameter  int ADDR_W = 8,
  parameter  int CNT_W  = 16,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cmd_valid,
  output logic [9:0]        cmd_data,
  input  logic              cmd_pop,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  input  logic              nack_evt,
  input  logic              arb_evt,
  input  logic              core_busy,
  output logic              core_en,
  output logic              fast_mode,
  output logic [CNT_W-1:0]  scl_lo_cnt,
  output logic [CNT_W-1:0]  scl_hi_cnt,
  output logic [CNT_W-1:0]  sda_hold_cnt,
  output logic              irq
);

  ctrl_t             ctrl;
  logic [IRQ_N-1:0]  ien, isr;
  logic              cmd_wr, rx_rd, isr_wr;
  logic [CMD_W-1:0]  cmd_wdata;
  logic [STK_N-1:0]  isr_clr;
  logic [LW-1:0]     cmd_lvl, rx_lvl;
  logic              cmd_full, cmd_empty, rx_full, rx_empty;
  logic [BYTE_W-1:0] rx_head;
  logic              flush, rx_pop_ok, ovf_evt;

  assign flush     = !ctrl.en;
  assign rx_pop_ok = rx_rd && !rx_empty;
  assign ovf_evt   = ctrl.en && rx_push && rx_full && !rx_pop_ok;

  i2cm_regbank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LW(LW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .rd_en     (reg_rd),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rx_head   (rx_head),
    .rx_empty  (rx_empty),
    .cmd_lvl   (cmd_lvl),
    .rx_lvl    (rx_lvl),
    .isr       (isr),
    .core_busy (core_busy),
    .ctrl      (ctrl),
    .ien       (ien),
    .scl_lo    (scl_lo_cnt),
    .scl_hi    (scl_hi_cnt),
    .sda_hold  (sda_hold_cnt),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .rx_rd     (rx_rd),
    .isr_wr    (isr_wr),
    .isr_clr   (isr_clr),
    .rdata     (reg_rdata)
  );

  i2cm_sfifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd_q (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (cmd_wr),
    .din   (cmd_wdata),
    .pop   (cmd_pop),
    .dout  (cmd_data),
    .full  (cmd_full),
    .empty (cmd_empty),
    .level (cmd_lvl)
  );

  i2cm_sfifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rx_q (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (rx_push),
    .din   (rx_byte),
    .pop   (rx_rd),
    .dout  (rx_head),
    .full  (rx_full),
    .empty (rx_empty),
    .level (rx_lvl)
  );

  i2cm_irq_unit #(.LW(LW)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .cmd_lvl  (cmd_lvl),
    .rx_lvl   (rx_lvl),
    .cmd_thr  (ctrl.cmd_thr),
    .rx_thr   (ctrl.rx_thr),
    .nack_evt (nack_evt),
    .arb_evt  (arb_evt),
    .ovf_evt  (ovf_evt),
    .clr_wr   (isr_wr),
    .clr_bits (isr_clr),
    .ien      (ien),
    .isr      (isr),
    .irq      (irq)
  );

  logic unused_full;
  assign unused_full = cmd_full;

  assign cmd_valid = !cmd_empty;
  assign core_en   = ctrl.en;
  assign fast_mode = ctrl.fast;

endmodule

// File: rtl/i2cm_csr_chk.sv
module i2cm_csr_chk
  import i2cm_csr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             rx_push,
  input logic             rx_full,
  input logic             rx_pop_ok,
  input logic [IRQ_N-1:0] isr,
  input logic [IRQ_N-1:0] ien,
  input logic             irq,
  input logic [LW-1:0]    cmd_lvl,
  input logic [LW-1:0]    rx_lvl,
  input logic             clr_wr,
  input logic [STK_N-1:0] clr_bits
);

  // R2 / R3: levels never exceed the queue depth
  p_lvl_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(cmd_lvl) <= DEPTH) && (int'(rx_lvl) <= DEPTH));

  // R4: a byte into a full, unread queue raises the overflow flag
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (rst)
    en && rx_push && rx_full && !rx_pop_ok |=> isr[IRQ_RXOF]);

  // R8: NACK flag holds unless cleared by a write of 1
  p_nack_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    isr[IRQ_NACK] && !(clr_wr && clr_bits[0]) |=> isr[IRQ_NACK]);

  // R8: arbitration flag holds unless cleared by a write of 1
  p_arb_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    isr[IRQ_ARB] && !(clr_wr && clr_bits[1]) |=> isr[IRQ_ARB]);

  // R9: enabled pending condition raises the line next cycle
  p_irq_on_r9: assert property (@(posedge clk) disable iff (rst)
    (|(isr & ien)) |=> irq);

  // R9: nothing enabled and pending drops the line next cycle
  p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(isr & ien)) |=> !irq);

  // R10: disabled core empties both queues
  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cmd_lvl == '0) && (rx_lvl == '0));

endmodule

bind i2cm_csr_front i2cm_csr_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (ctrl.en),
  .rx_push   (rx_push),
  .rx_full   (rx_full),
  .rx_pop_ok (rx_pop_ok),
  .isr       (isr),
  .ien       (ien),
  .irq       (irq),
  .cmd_lvl   (cmd_lvl),
  .rx_lvl    (rx_lvl),
  .clr_wr    (isr_wr),
  .clr_bits  (isr_clr)
);

// File: tb/test_i2cm_csr_front.sv
`timescale 1ns/1ps
module test_i2cm_csr_front;

  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid;
  logic [9:0]  cmd_data;
  logic        cmd_pop = 1'b0;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        nack_evt = 1'b0, arb_evt = 1'b0, core_busy = 1'b0;
  logic        core_en, fast_mode, irq;
  logic [CNT_W-1:0] scl_lo_cnt, scl_hi_cnt, sda_hold_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2cm_csr_front #(.DEPTH(4), .ADDR_W(8), .CNT_W(CNT_W)) i_i2cm_csr_front (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .nack_evt(nack_evt),
    .arb_evt(arb_evt), .core_busy(core_busy), .core_en(core_en),
    .fast_mode(fast_mode), .scl_lo_cnt(scl_lo_cnt), .scl_hi_cnt(scl_hi_cnt),
    .sda_hold_cnt(sda_hold_cnt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic rx_in(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_byte = b;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pop_cmd();
    @(negedge clk); cmd_pop = 1'b1;
    @(negedge clk); cmd_pop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart_core(input logic [31:0] ctrl_val);
    wr(8'h08, 32'h0);
    idle(1);
    wr(8'h08, ctrl_val);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 core_en", core_en, 0);
    chk("R1 scl_lo", scl_lo_cnt, 0);
    rd(8'h08, d); chk("R1 ctrl", d, 0);
    rd(8'h0C, d); chk("R1 ien", d, 0);
    rd(8'h18, d); chk("R1 cmd level", d, 0);
    rd(8'h1C, d); chk("R1 rx level", d, 0);
    rd(8'h10, d); chk("R1 status", d, 32'h01);
  endtask

  task automatic t_cmd_queue();
    logic [31:0] d;
    wr(8'h08, 32'h01);
    chk("R5 core_en", core_en, 1);
    wr(8'h00, 32'h2A5); wr(8'h00, 32'h033); wr(8'h00, 32'h1C3);
    rd(8'h18, d); chk("R2 level 3", d, 3);
    chk("R2 valid", cmd_valid, 1);
    chk("R2 head", cmd_data, 10'h2A5);
    pop_cmd(); chk("R2 second", cmd_data, 10'h033);
    pop_cmd(); chk("R2 third", cmd_data, 10'h1C3);
    pop_cmd(); chk("R2 empty valid", cmd_valid, 0);
    for (int i = 1; i <= 5; i++) wr(8'h00, 32'h100 + i);
    rd(8'h18, d); chk("R2 full level", d, 4);
    for (int i = 1; i <= 4; i++) begin
      chk("R2 full order", cmd_data, 10'h100 + 10'(i));
      pop_cmd();
    end
    chk("R2 fifth dropped", cmd_valid, 0);
  endtask

  task automatic t_rx_queue();
    logic [31:0] d;
    rx_in(8'h11); rx_in(8'h22);
    rd(8'h1C, d); chk("R3 level 2", d, 2);
    rd(8'h04, d); chk("R3 first byte", d, 32'h11);
    rd(8'h04, d); chk("R3 second byte", d, 32'h22);
    rd(8'h04, d); chk("R3 empty read", d, 0);
    rd(8'h1C, d); chk("R3 level 0", d, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) rx_in(8'h40 + 8'(i));
    rd(8'h1C, d); chk("R4 level stays 4", d, 4);
    rd(8'h10, d); chk("R4 overflow flag", d, 32'h13);
    for (int i = 0; i < 4; i++) begin
      rd(8'h04, d); chk("R4 kept bytes", d, 32'h40 + i);
    end
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R8 write 0 keeps flag", d, 32'h11);
    wr(8'h10, 32'h10);
    rd(8'h10, d); chk("R8 write 1 clears", d, 32'h01);
  endtask

  task automatic t_thresholds();
    logic [31:0] d;
    restart_core(32'h1B);
    chk("R5 fast_mode", fast_mode, 1);
    rd(8'h08, d); chk("R5 ctrl readback", d, 32'h1B);
    wr(8'h00, 32'h1); wr(8'h00, 32'h2);
    rd(8'h10, d); chk("R6 ready at threshold", d[0], 1);
    wr(8'h00, 32'h3);
    rd(8'h10, d); chk("R6 not ready above", d[0], 0);
    rx_in(8'hA1);
    rd(8'h10, d); chk("R7 not ready at threshold", d[1], 0);
    rx_in(8'hA2);
    rd(8'h10, d); chk("R7 ready above", d[1], 1);
    restart_core(32'h01);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    @(negedge clk); nack_evt = 1'b1; @(negedge clk); nack_evt = 1'b0;
    @(negedge clk); arb_evt = 1'b1;  @(negedge clk); arb_evt = 1'b0;
    rd(8'h10, d); chk("R8 nack and arb set", d, 32'h0D);
    wr(8'h10, 32'h04);
    rd(8'h10, d); chk("R8 clear nack only", d, 32'h09);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h08; arb_evt = 1'b1;
    @(negedge clk); reg_wr = 1'b0; arb_evt = 1'b0;
    rd(8'h10, d); chk("R8 set wins over clear", d, 32'h09);
    wr(8'h10, 32'h08);
    rd(8'h10, d); chk("R8 arb cleared", d, 32'h01);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h0C, 32'h04);
    idle(2); chk("R9 no irq before event", irq, 0);
    @(negedge clk); nack_evt = 1'b1; @(negedge clk); nack_evt = 1'b0;
    idle(1); chk("R9 irq on nack", irq, 1);
    wr(8'h0C, 32'h00);
    idle(1); chk("R9 irq masked", irq, 0);
    wr(8'h10, 32'h04);
    wr(8'h0C, 32'h01);
    idle(1); chk("R9 irq on cmd ready", irq, 1);
    wr(8'h00, 32'h055);
    idle(1); chk("R9 irq drops when level above", irq, 0);
    pop_cmd();
    wr(8'h0C, 32'h00);
    rd(8'h0C, d); chk("R9 ien readback", d, 0);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    wr(8'h00, 32'h0AA); wr(8'h00, 32'h0BB);
    rx_in(8'h01); rx_in(8'h02);
    wr(8'h08, 32'h00);
    idle(1);
    chk("R10 cmd_valid after disable", cmd_valid, 0);
    rd(8'h18, d); chk("R10 cmd flushed", d, 0);
    rd(8'h1C, d); chk("R10 rx flushed", d, 0);
    wr(8'h00, 32'h0CC);
    for (int i = 0; i < 5; i++) rx_in(8'h70);
    rd(8'h18, d); chk("R10 cmd write ignored", d, 0);
    rd(8'h1C, d); chk("R10 rx push ignored", d, 0);
    rd(8'h10, d); chk("R10 no overflow", d[4], 0);
    wr(8'h08, 32'h01);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    wr(8'h20, 32'h0064); wr(8'h24, 32'h0032); wr(8'h28, 32'h0003);
    rd(8'h20, d); chk("R11 low readback", d, 32'h64);
    rd(8'h24, d); chk("R11 high readback", d, 32'h32);
    rd(8'h28, d); chk("R11 hold readback", d, 32'h03);
    chk("R11 low out", scl_lo_cnt, 16'h64);
    chk("R11 high out", scl_hi_cnt, 16'h32);
    chk("R11 hold out", sda_hold_cnt, 16'h03);
    core_busy = 1'b1;
    rd(8'h14, d); chk("R11 busy", d, 1);
    core_busy = 1'b0;
    rd(8'h14, d); chk("R11 idle", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cmd_queue();
    t_rx_queue();
    t_overflow();
    t_thresholds();
    t_sticky();
    t_irq();
    t_flush();
    t_timing();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule